// File: doc/BRIEF.md
# Trellis Add-Compare-Select with Zero-State Forcing

This block is the path-metric engine of a rate-1/2, constraint-length-7 soft-decision convolutional decoder. It keeps one metric for each of the 64 trellis states and advances all of them in a single clock. Each state has two predecessors. For each state the block adds the branch cost to both predecessor metrics and keeps the smaller sum. It records which predecessor won as one decision bit. The 64 decision bits go to a traceback unit. The block also reports the state with the smallest metric, which serves as the starting point for traceback.

The four branch costs come from outside the block, one for each possible pair of coded output bits. A single synchronous control line, `trellisRst`, frames a burst. At the edge where it is high, the stage being consumed may only end in state zero. In the stage that follows that edge, paths may only leave state zero. Raising the line one clock before the first symbol pair starts a burst. Raising it during the last tail symbols closes the burst. Holding it high for two clocks does both, and leaves only the zero-to-zero branch in the second stage.

Path metrics wrap around modulo their width and are never renormalised. The width is chosen large enough that any two live metrics can be compared by the sign of their difference. A disallowed branch is given the state-zero metric plus a fixed penalty. That penalty is larger than any spread that real paths can reach, so a disallowed branch always loses.

Top module: `trellis_acs`

## Requirements
- R1: The 64 states are 6-bit values. State n is entered from states 2*(n mod 32) and 2*(n mod 32)+1, and the input bit on that branch equals bit 5 of n.
- R2: The branch from predecessor p with input bit u forms the 7-bit word {u, p[5:0]}. Its coded bits are c0 = parity(word AND 171 octal) and c1 = parity(word AND 133 octal). It uses the branch cost on `bmIn[2*c0 + c1]`.
- R3: Once per rising edge, each state's new metric becomes the smaller of its two candidate sums. Its bit in `decOut` becomes 1 only if the candidate from the odd (higher-index) predecessor is strictly smaller. A tie gives 0.
- R4: When `trellisRst` is high at an edge, the stage consumed at that edge keeps only branches ending in state 0. After that edge, `decOut[63:1]` is all zero and `bestState` is 0.
- R5: In the stage consumed at the edge after a `trellisRst` edge, only branches leaving state 0 count. After that stage `decOut` is all zero and `bestState` is 0 or 32.
- R6: `bestState` is the index of the smallest current metric, found with modular comparison. On a tie the lowest index wins. It follows the metrics loaded at the latest edge.
- R7: Metrics are PM_W = BM_W + 6 bits wide and wrap modulo 2^PM_W with no renormalisation. Decisions and `bestState` stay the same as with unbounded arithmetic over arbitrarily long runs.
- R8: A disallowed candidate takes the value of the state-0 metric before the edge plus 2^(PM_W-2). When `trellisRst` is high on two consecutive edges, only the zero-to-zero branch survives the second stage, and every decision bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one trellis stage per edge |
| trellisRst | input | 1 | Synchronous burst framing control: ends a stage in state 0 and starts the next from it |
| bmIn | input | 4 x BM_W | Branch costs, indexed by the coded bit pair {c0, c1} |
| decOut | output | 64 | Survivor decision bit for each state, from the latest stage |
| bestState | output | 6 | Index of the smallest path metric |

## Verification
The properties assume that `trellisRst` is low or high at every edge and never unknown. They also assume that the branch costs stay within BM_W bits, so the spread between live metrics stays under the penalty that marks a disallowed candidate. The stimulus drives every input on the falling edge, so nothing changes near a rising edge. Each framing pulse lasts one or two clocks, which lets the reset-window properties see the stage after the pulse. The costs come from full-range random values, tie-heavy all-zero patterns and single-cheap-label patterns. This keeps them in range while driving the metrics through many wrap-arounds.

// File: rtl/trellis_acs_pkg.sv
package trellis_acs_pkg;

  // Strobes passed from the control to the datapath for one trellis stage
  typedef struct packed {
    logic startStage;  // only branches leaving state 0 count
    logic endStage;    // only branches entering state 0 count
  } stageCtl_t;

  // Coded bit pair {c0, c1} of an encoder word under two generator taps
  function automatic logic [1:0] branchLabel(input logic [31:0] encWord,
                                             input logic [31:0] tapsA,
                                             input logic [31:0] tapsB);
    return {^(encWord & tapsA), ^(encWord & tapsB)};
  endfunction

endpackage

// File: rtl/trellis_acs_ctrl.sv
module trellis_acs_ctrl
  import trellis_acs_pkg::*;
(
  input  logic      clk,
  input  logic      trellisRst,
  output stageCtl_t stageCtl
);

  // Remember the framing edge so the following stage starts from state 0
  logic rstSeen;

  always_ff @(posedge clk) begin
    rstSeen <= trellisRst;
  end

  always_comb begin
    stageCtl.startStage = rstSeen;
    stageCtl.endStage   = trellisRst;
  end

endmodule

// File: rtl/trellis_acs_cell.sv
module trellis_acs_cell #(
  parameter int PM_W = 10
) (
  input  logic [PM_W-1:0] candEven,
  input  logic [PM_W-1:0] candOdd,
  output logic [PM_W-1:0] survivor,
  output logic            pickOdd
);

  // The sign of the wrapped difference orders the two candidates
  logic [PM_W-1:0] gap;

  always_comb begin
    gap      = candOdd - candEven;
    pickOdd  = gap[PM_W-1];
    survivor = pickOdd ? candOdd : candEven;
  end

endmodule

// File: rtl/trellis_acs_datapath.sv
module trellis_acs_datapath
  import trellis_acs_pkg::*;
#(
  parameter int           K    = 7,
  parameter int           BM_W = 4,
  parameter int           PM_W = 10,
  parameter logic [K-1:0] G0   = 7'o171,
  parameter logic [K-1:0] G1   = 7'o133
) (
  input  logic                               clk,
  input  stageCtl_t                          stageCtl,
  input  logic [3:0][BM_W-1:0]               bmIn,
  output logic [2**(K-1)-1:0][PM_W-1:0]      metricOut,
  output logic [2**(K-1)-1:0]                decOut
);

  localparam int NS   = 2 ** (K - 1);
  localparam int HALF = NS / 2;
  localparam logic [PM_W-1:0] PENALTY = {2'b01, {(PM_W - 2){1'b0}}};

  logic [NS-1:0][PM_W-1:0] metricQ;
  logic [NS-1:0][PM_W-1:0] metricD;
  logic [NS-1:0]           decD;
  logic [NS-1:0]           decQ;
  logic [PM_W-1:0]         blockedVal;

  // Value given to any disallowed candidate
  assign blockedVal = metricQ[0] + PENALTY;

  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int PE = (s % HALF) * 2;
    localparam int PO = PE + 1;
    localparam int UB = s / HALF;
    localparam logic [31:0] ENC_E = (32'(UB) << (K - 1)) | 32'(PE);
    localparam logic [31:0] ENC_O = (32'(UB) << (K - 1)) | 32'(PO);
    localparam logic [1:0] LBL_E = branchLabel(ENC_E, 32'(G0), 32'(G1));
    localparam logic [1:0] LBL_O = branchLabel(ENC_O, 32'(G0), 32'(G1));
    localparam bit EVEN_IS_ZERO = (PE == 0);
    localparam bit DEST_IS_ZERO = (s == 0);

    logic            okEven;
    logic            okOdd;
    logic [PM_W-1:0] candEven;
    logic [PM_W-1:0] candOdd;

    always_comb begin
      okEven = (!stageCtl.startStage || EVEN_IS_ZERO) &&
               (!stageCtl.endStage || DEST_IS_ZERO);
      okOdd  = !stageCtl.startStage &&
               (!stageCtl.endStage || DEST_IS_ZERO);
      candEven = okEven ? metricQ[PE] + {{(PM_W - BM_W){1'b0}}, bmIn[LBL_E]}
                        : blockedVal;
      candOdd  = okOdd  ? metricQ[PO] + {{(PM_W - BM_W){1'b0}}, bmIn[LBL_O]}
                        : blockedVal;
    end

    trellis_acs_cell #(.PM_W(PM_W)) u_cell (
      .candEven (candEven),
      .candOdd  (candOdd),
      .survivor (metricD[s]),
      .pickOdd  (decD[s])
    );
  end

  always_ff @(posedge clk) begin
    metricQ <= metricD;
    decQ    <= decD;
  end

  assign metricOut = metricQ;
  assign decOut    = decQ;

endmodule

// File: rtl/trellis_acs_best.sv
module trellis_acs_best #(
  parameter int NS   = 64,
  parameter int PM_W = 10,
  parameter int SW   = 6
) (
  input  logic [NS-1:0][PM_W-1:0] metricIn,
  output logic [SW-1:0]           bestIdx
);

  // Heap-ordered comparison tree: node i has children 2i+1 and 2i+2
  localparam int NODES = 2 * NS - 1;

  logic [NODES-1:0][PM_W-1:0] nodeVal;
  logic [NODES-1:0][SW-1:0]   nodeIdx;

  for (genvar j = 0; j < NS; j++) begin : g_leaf
    assign nodeVal[NS - 1 + j] = metricIn[j];
    assign nodeIdx[NS - 1 + j] = SW'(j);
  end

  for (genvar i = 0; i < NS - 1; i++) begin : g_node
    logic [PM_W-1:0] gap;
    logic            takeRight;
    always_comb begin
      gap        = nodeVal[2 * i + 2] - nodeVal[2 * i + 1];
      takeRight  = gap[PM_W-1];
      nodeVal[i] = takeRight ? nodeVal[2 * i + 2] : nodeVal[2 * i + 1];
      nodeIdx[i] = takeRight ? nodeIdx[2 * i + 2] : nodeIdx[2 * i + 1];
    end
  end

  assign bestIdx = nodeIdx[0];

endmodule

// File: rtl/trellis_acs.sv
module trellis_acs
  import trellis_acs_pkg::*;
#(
  parameter int           K    = 7,
  parameter int           BM_W = 4,
  parameter logic [K-1:0] G0   = 7'o171,
  parameter logic [K-1:0] G1   = 7'o133
) (
  input  logic                   clk,
  input  logic                   trellisRst,
  input  logic [3:0][BM_W-1:0]   bmIn,
  output logic [2**(K-1)-1:0]    decOut,
  output logic [K-2:0]           bestState
);

  localparam int NS   = 2 ** (K - 1);
  localparam int SW   = K - 1;
  localparam int PM_W = BM_W + 2 + $clog2(2 * (K - 1));

  stageCtl_t               stageCtl;
  logic [NS-1:0][PM_W-1:0] metrics;

  trellis_acs_ctrl u_ctrl (
    .clk        (clk),
    .trellisRst (trellisRst),
    .stageCtl   (stageCtl)
  );

  trellis_acs_datapath #(
    .K(K), .BM_W(BM_W), .PM_W(PM_W), .G0(G0), .G1(G1)
  ) u_dp (
    .clk       (clk),
    .stageCtl  (stageCtl),
    .bmIn      (bmIn),
    .metricOut (metrics),
    .decOut    (decOut)
  );

  trellis_acs_best #(.NS(NS), .PM_W(PM_W), .SW(SW)) u_best (
    .metricIn (metrics),
    .bestIdx  (bestState)
  );

endmodule

// File: rtl/trellis_acs_chk.sv
module trellis_acs_chk #(
  parameter int NS = 64,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          trellisRst,
  input logic [NS-1:0] decOut,
  input logic [SW-1:0] bestState
);

  // R4
  end_stage_chk: assert property (@(posedge clk) disable iff (trellisRst)
    $fell(trellisRst) |-> (decOut[NS-1:1] == '0));

  // R4
  end_best_chk: assert property (@(posedge clk) disable iff (trellisRst)
    $fell(trellisRst) |-> (bestState == '0));

  // R5
  start_stage_chk: assert property (@(posedge clk) disable iff (trellisRst)
    ($past(trellisRst, 2) && !$past(trellisRst)) |-> (decOut == '0));

  // R5
  start_best_chk: assert property (@(posedge clk) disable iff (trellisRst)
    ($past(trellisRst, 2) && !$past(trellisRst)) |-> (bestState[SW-2:0] == '0));

  // R8
  double_rst_chk: assert property (@(posedge clk) disable iff (trellisRst)
    ($past(trellisRst, 2) && $past(trellisRst)) |-> (decOut == '0));

  // R6
  best_known_chk: assert property (@(posedge clk) disable iff (trellisRst)
    !$isunknown(bestState));

endmodule

bind trellis_acs trellis_acs_chk #(.NS(NS), .SW(SW)) u_chk (
  .clk        (clk),
  .trellisRst (trellisRst),
  .decOut     (decOut),
  .bestState  (bestState)
);

// File: tb/trellis_acs_test.sv
module trellis_acs_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  NS         = 64;
  localparam int  BMW        = 4;
  localparam int  PMW        = BMW + 6;
  localparam longint PEN     = 64'(1) << (PMW - 2);
  localparam int  TAPS_A     = 'o171;
  localparam int  TAPS_B     = 'o133;

  logic                  clk = 1'b0;
  logic                  trellisRst = 1'b1;
  logic [3:0][BMW-1:0]   bmIn = '0;
  logic [NS-1:0]         decOut;
  logic [5:0]            bestState;

  trellis_acs uut (
    .clk        (clk),
    .trellisRst (trellisRst),
    .bmIn       (bmIn),
    .decOut     (decOut),
    .bestState  (bestState)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int        errors = 0;
  int        checks = 0;
  longint    pm [NS];
  bit [NS-1:0] rDec;
  int        rBest;
  bit        prevRst = 1'b0;
  bit        cmpOn = 1'b0;
  bit        armed = 1'b0;
  string     decTag = "R3";
  string     bestTag = "R6";

  function automatic int labelOf(int u, int p);
    int w = (u << 6) | p;
    int a = $countones(w & TAPS_A) & 1;
    int b = $countones(w & TAPS_B) & 1;
    return a * 2 + b;
  endfunction

  task automatic refStage(input bit st, input bit en, input int bm [4]);
    longint nx [NS];
    longint c [2];
    for (int s = 0; s < NS; s++) begin
      int pe = (s % 32) * 2;
      int u  = s / 32;
      for (int k = 0; k < 2; k++) begin
        int p = pe + k;
        bit ok = (!st || p == 0) && (!en || s == 0);
        c[k] = ok ? pm[p] + bm[labelOf(u, p)] : pm[0] + PEN;
      end
      rDec[s] = (c[1] < c[0]);
      nx[s]   = rDec[s] ? c[1] : c[0];
    end
    rBest = 0;
    for (int s = 0; s < NS; s++) begin
      pm[s] = nx[s];
      if (nx[s] < nx[rBest]) rBest = s;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: compare last stage, drive the next inputs, advance the model
  task automatic step(input bit r, input int b0, input int b1, input int b2,
                      input int b3, input string phaseTag);
    int bm [4];
    @(negedge clk);
    if (cmpOn) begin
      checks++;
      if (decOut !== rDec) begin
        errors++;
        $display("FAIL %s decisions: actual %h expected %h", decTag, decOut, rDec);
      end
      check(bestState === 6'(rBest), bestTag, "bestState", 64'(bestState), 64'(rBest));
    end
    bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
    trellisRst = r;
    bmIn = {4'(b3), 4'(b2), 4'(b1), 4'(b0)};
    refStage(prevRst, r, bm);
    if (prevRst && r) begin decTag = "R8"; bestTag = "R8"; end
    else if (r)       begin decTag = "R4"; bestTag = "R4"; end
    else if (prevRst) begin decTag = "R5"; bestTag = "R5"; end
    else              begin decTag = phaseTag; bestTag = "R6"; end
    if (prevRst && r) armed = 1'b1;
    cmpOn = armed;
    prevRst = r;
  endtask

  task automatic randStep(input bit r, input string tag);
    step(r, $urandom_range(0, 15), $urandom_range(0, 15),
         $urandom_range(0, 15), $urandom_range(0, 15), tag);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) pm[s] = 0;
    // Two framing edges put the trellis in a known state (R8)
    step(1'b1, 3, 5, 7, 9, "R8");
    step(1'b1, 2, 4, 6, 8, "R8");
    // R4 R8 reset state: all decisions zero, best state zero
    step(1'b0, 1, 2, 3, 4, "R5");
    check(decOut == '0, "R8", "reset decisions", 64'(decOut), 0);
    check(bestState == 6'd0, "R4", "reset bestState", 64'(bestState), 0);
    // R1 R3 random costs
    for (int i = 0; i < 300; i++) randStep(1'b0, "R1");
    // R2 one cheap label at a time
    for (int i = 0; i < 64; i++) begin
      int cheap = (i / 8) % 4;
      step(1'b0, cheap == 0 ? 0 : 15, cheap == 1 ? 0 : 15,
           cheap == 2 ? 0 : 15, cheap == 3 ? 0 : 15, "R2");
    end
    // R3 R6 ties everywhere
    for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 20; i++) step(1'b0, 7, 7, 7, 7, "R3");
    // R4 R5 burst framing with single pulses
    for (int b = 0; b < 12; b++) begin
      for (int i = 0; i < 20 + b; i++) randStep(1'b0, "R1");
      randStep(1'b1, "R4");
      randStep(1'b0, "R5");
      check(bestState == 6'd0, "R4", "bestState after end stage", 64'(bestState), 0);
      randStep(1'b0, "R5");
      check(bestState[4:0] == 5'd0, "R5", "bestState after start stage",
            64'(bestState), 0);
    end
    // R8 double framing pulses
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 15; i++) randStep(1'b0, "R1");
      randStep(1'b1, "R8");
      randStep(1'b1, "R8");
      randStep(1'b0, "R8");
      check(decOut == '0, "R8", "double framing decisions", 64'(decOut), 0);
    end
    // R7 long run with heavy costs to wrap the metrics many times
    for (int i = 0; i < 4000; i++) begin
      if (i % 3 == 0) step(1'b0, 15, 15, 14, 15, "R7");
      else randStep(1'b0, "R7");
    end
    step(1'b0, 0, 0, 0, 0, "R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule